// File: doc/BRIEF.md
# Repeated Memory Scan Engine

This block walks a region of byte-addressed memory one element at a time and compares each element with a search key. It stops at the first element that satisfies a chosen stop condition, or when an element budget runs out. A caller loads a start address, an element budget, the key, an element width of 8, 16 or 32 bits, a stepping direction and a stop rule, then pulses `start`. The engine then issues reads through a simple synchronous port whose data returns one cycle after the read strobe.

Each comparison subtracts the memory element from the key at the selected width. The engine writes to nothing. When the scan ends it reports the address that follows the last element it compared, the budget that is left, and the zero, sign, carry and overflow results of the final subtraction. The zero result tells a caller whether the scan ended on the stop condition or because the budget ran out.

Top module: `str_scan`

## Requirements
- R1: Each element is compared by subtracting it from the key at the element width. `esize` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. The element is taken from the low bits of `rd_data`, the key from the low bits of `key`, and wider bits are ignored. On completion `zf` is 1 when the difference is zero, `sf` is the top bit of the difference, `cf` is 1 when the unsigned element exceeds the unsigned key, and `of` flags signed overflow of the subtraction.
- R2: After every compared element, including the one that ends the scan, the pointer moves by 1, 2 or 4 for widths 8, 16 and 32. It moves up when `dir` is 0 and down when `dir` is 1, wrapping modulo 2^AW. `end_addr` reports the final pointer.
- R3: With `mode` 0 the scan stops after the first element equal to the key, or when the budget reaches zero.
- R4: With `mode` 1 the scan stops after the first element not equal to the key, or when the budget reaches zero.
- R5: The budget is decremented once per compared element, and `end_cnt` reports what is left when the scan ends.
- R6: A start with a budget of zero issues no read, pulses `done` in the cycle after the start, leaves all four flags unchanged, and reports `end_addr` equal to the start address and `end_cnt` equal to 0.
- R7: Reads are one cycle long and never back to back. A scan of N elements pulses `done` 2N cycles after the clock edge that accepts `start`, and issues exactly N reads.
- R8: A `start` pulse that arrives while `busy` is high has no effect on the scan in progress.
- R9: After reset `done`, `busy`, `rd_en` and all flags are 0. `done` is a single-cycle pulse, and the results hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan when idle |
| start_addr | input | AW | First element address |
| start_cnt | input | CW | Number of elements to examine |
| key | input | 32 | Search key, low bits used |
| esize | input | 2 | Element width: 0 byte, 1 half, 2/3 word |
| dir | input | 1 | 0 step up, 1 step down |
| mode | input | 1 | 0 stop on equal, 1 stop on unequal |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | AW | Read address |
| rd_data | input | 32 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| end_addr | output | AW | Pointer after the last compared element |
| end_cnt | output | CW | Remaining budget |
| zf | output | 1 | Zero result of last compare |
| sf | output | 1 | Sign result of last compare |
| cf | output | 1 | Borrow of last compare |
| of | output | 1 | Signed overflow of last compare |

## Verification
The hardest cases to reach from the ports are a `start` that lands in the middle of a scan and a zero-budget start that must leave the flags from an earlier scan in place. The bench sets up both. It sends a second start with different operands a few cycles into a long scan and checks that the result still matches the first request. It runs a zero-budget start straight after a scan that left nonzero flags and checks that those flags survive. Memory is filled so that runs of equal bytes, a signed-overflow compare and address wrap below zero can each be reached by one scan.

// File: rtl/str_scan.sv
module str_scan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_cnt,
  input  logic [31:0]   key,
  input  logic [1:0]    esize,
  input  logic          dir,
  input  logic          mode,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] end_addr,
  output logic [CW-1:0] end_cnt,
  output logic          zf,
  output logic          sf,
  output logic          cf,
  output logic          of
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_CMP} st_t;

  st_t           st;
  logic [AW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic [31:0]   key_q;
  logic [1:0]    esz_q;
  logic          dir_q, mode_q, done_q;
  logic          zf_q, sf_q, cf_q, of_q;

  logic [4:0]    sh;
  logic [31:0]   a_al, b_al;
  logic [32:0]   dif;
  logic          n_zf, n_sf, n_cf, n_of, stop;
  logic [AW-1:0] step, ptr_nx;
  logic [CW-1:0] cnt_nx;

  assign sh     = (esz_q == 2'd0) ? 5'd24 : (esz_q == 2'd1) ? 5'd16 : 5'd0;
  assign a_al   = key_q << sh;
  assign b_al   = rd_data << sh;
  assign dif    = {1'b0, a_al} - {1'b0, b_al};
  assign n_zf   = (dif[31:0] == 32'd0);
  assign n_sf   = dif[31];
  assign n_cf   = dif[32];
  assign n_of   = (a_al[31] ^ b_al[31]) & (dif[31] ^ a_al[31]);

  assign step   = (esz_q == 2'd0) ? AW'(1) : (esz_q == 2'd1) ? AW'(2) : AW'(4);
  assign ptr_nx = dir_q ? ptr - step : ptr + step;
  assign cnt_nx = cnt - CW'(1);
  assign stop   = (cnt_nx == '0) || (mode_q ? !n_zf : n_zf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      cnt    <= '0;
      key_q  <= '0;
      esz_q  <= '0;
      dir_q  <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      zf_q   <= 1'b0;
      sf_q   <= 1'b0;
      cf_q   <= 1'b0;
      of_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ptr    <= start_addr;
          cnt    <= start_cnt;
          key_q  <= key;
          esz_q  <= esize;
          dir_q  <= dir;
          mode_q <= mode;
          if (start_cnt == '0) done_q <= 1'b1;
          else                 st     <= S_RD;
        end
        S_RD: st <= S_CMP;
        S_CMP: begin
          ptr  <= ptr_nx;
          cnt  <= cnt_nx;
          zf_q <= n_zf;
          sf_q <= n_sf;
          cf_q <= n_cf;
          of_q <= n_of;
          if (stop) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_en    = (st == S_RD);
  assign rd_addr  = ptr;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign end_addr = ptr;
  assign end_cnt  = cnt;
  assign zf       = zf_q;
  assign sf       = sf_q;
  assign cf       = cf_q;
  assign of       = of_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R7
  AST_STOP_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st == S_CMP)) |-> (end_cnt == '0 || (mode_q ? !zf : zf))); // R3
  AST_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_cnt == '0) |=> (done && !rd_en && zf == $past(zf) && cf == $past(cf))); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(key_q) && $stable(mode_q) && $stable(esz_q))); // R8
endmodule

// File: tb/str_scan_tb.sv
module str_scan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] start_cnt = '0;
  logic [31:0] key = '0;
  logic [1:0]  esize = '0;
  logic        dir = 1'b0, mode = 1'b0;
  logic        rd_en, busy, done, zf, sf, cf, of;
  logic [15:0] rd_addr, end_addr, end_cnt;
  logic [31:0] rd_data = '0;

  always #2.5 clk = ~clk;

  str_scan u_dut (.clk, .rst_n, .start, .start_addr, .start_cnt, .key, .esize, .dir, .mode,
    .rd_en, .rd_addr, .rd_data, .busy, .done, .end_addr, .end_cnt, .zf, .sf, .cf, .of);

  logic [7:0] mem [256];
  int total = 0, bad = 0, nreads = 0, cycles = 0;

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= {mem[8'(rd_addr[7:0] + 8'd3)], mem[8'(rd_addr[7:0] + 8'd2)],
                  mem[8'(rd_addr[7:0] + 8'd1)], mem[rd_addr[7:0]]};
      nreads <= nreads + 1;
    end
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected flags carried across scans (for zero-budget starts)
  logic mz = 0, ms = 0, mc = 0, mo = 0;

  task automatic model(input logic [15:0] a0, input logic [15:0] c0, input logic [31:0] k,
                       input logic [1:0] es, input logic d, input logic m,
                       output logic [15:0] ea, output logic [15:0] ec, output int nel);
    int w = (es == 0) ? 8 : (es == 1) ? 16 : 32;
    logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    logic [31:0] kk = k & mask;
    logic [15:0] p = a0, c = c0;
    nel = 0;
    while (c != 0) begin
      logic [31:0] e = 0, df;
      for (int i = 0; i < 4; i++) e[8*i +: 8] = mem[8'(p[7:0] + 8'(i))];
      e = e & mask;
      df = (kk - e) & mask;
      mz = (df == 0);
      ms = df[w-1];
      mc = (e > kk);
      mo = (kk[w-1] != e[w-1]) && (df[w-1] != kk[w-1]);
      p = d ? p - 16'(w/8) : p + 16'(w/8);
      c = c - 1;
      nel++;
      if (m == 0 && mz) break;
      if (m == 1 && !mz) break;
    end
    ea = p; ec = c;
  endtask

  task automatic run(input logic [15:0] a0, input logic [15:0] c0, input logic [31:0] k,
                     input logic [1:0] es, input logic d, input logic m, input bit inject,
                     input string tag);
    logic [15:0] ea, ec;
    int nel, cyc;
    model(a0, c0, k, es, d, m, ea, ec, nel);
    @(negedge clk);
    start_addr = a0; start_cnt = c0; key = k; esize = es; dir = d; mode = m;
    start = 1'b1; nreads = 0;
    @(posedge clk); cyc = 1; #1; start = 1'b0;
    while (!done && cyc < 1000) begin
      if (inject && cyc == 3) begin
        start_addr = 16'h0000; start_cnt = 16'd1; key = 32'h0; esize = 2'd2; mode = ~m; start = 1'b1;
      end
      @(posedge clk); cyc++; #1;
      start = 1'b0;
    end
    chk({tag, " R7 latency"}, cyc, 2*nel + 1);
    chk({tag, " R7 reads"}, nreads, nel);
    chk({tag, " R2 end_addr"}, end_addr, ea);
    chk({tag, " R5 end_cnt"}, end_cnt, ec);
    chk({tag, " R1 flags"}, {zf, sf, cf, of}, {mz, ms, mc, mo});
    @(posedge clk); #1;
    chk({tag, " R9 done pulse"}, done, 0);
  endtask

  // addr, cnt, key, esize, dir, mode
  localparam logic [67:0] VEC [10] = '{
    {16'h0010, 16'd100, 32'h0000_0020, 2'd0, 1'b0, 1'b0},  // R3 found, up
    {16'h0000, 16'd16,  32'h0000_00F0, 2'd0, 1'b0, 1'b0},  // R3 exhausted
    {16'h000A, 16'd20,  32'h0000_0005, 2'd0, 1'b1, 1'b0},  // R2 down
    {16'h0080, 16'd40,  32'h0000_00AA, 2'd0, 1'b0, 1'b1},  // R4 mismatch ends run
    {16'h0082, 16'd4,   32'h0000_00AA, 2'd0, 1'b0, 1'b1},  // R4 exhausted while equal
    {16'h0030, 16'd50,  32'hDEAD_4948, 2'd1, 1'b0, 1'b0},  // R1 half, upper key bits ignored
    {16'h0070, 16'd10,  32'h6362_6160, 2'd2, 1'b1, 1'b0},  // R2 word step down
    {16'h0000, 16'd3,   32'h8000_0000, 2'd2, 1'b0, 1'b1},  // R1 signed overflow
    {16'h0001, 16'd5,   32'h0000_0000, 2'd0, 1'b0, 1'b1},  // R1 borrow and sign
    {16'h0001, 16'd5,   32'h0000_0077, 2'd0, 1'b1, 1'b0}   // R2 wrap below zero
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    for (int i = 8'h80; i < 8'h90; i++) mem[i] = 8'hAA;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset done", done, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset rd_en", rd_en, 0);
    chk("R9 reset flags", {zf, sf, cf, of}, 4'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      run(VEC[v][67:52], VEC[v][51:36], VEC[v][35:4], VEC[v][3:2], VEC[v][1], VEC[v][0], 1'b0,
          $sformatf("vec%0d", v));
    end

    // R6: zero budget after a scan that left sf and cf set
    run(16'h0001, 16'd1, 32'h0, 2'd0, 1'b0, 1'b1, 1'b0, "pre-R6");
    run(16'h1234, 16'd0, 32'h55, 2'd0, 1'b0, 1'b0, 1'b0, "R6 zero");
    chk("R6 addr kept", end_addr, 16'h1234);
    chk("R6 flags kept", {zf, sf, cf, of}, 4'b0110);

    // R8: second start while busy is ignored
    run(16'h0010, 16'd100, 32'h0000_0020, 2'd0, 1'b0, 1'b0, 1'b1, "R8 busy start");

    // R9: results hold after completion
    repeat (5) @(posedge clk);
    #1;
    chk("R9 hold addr", end_addr, 16'h0021);
    chk("R9 hold cnt", end_cnt, 16'd83);
    chk("R9 idle", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule